// File: doc/BRIEF.md
# Link packet byte serializer

This block takes 104-bit transaction packets from a system-side channel and emits them as a framed byte stream for a point-to-point chip link. One byte goes out per link clock. The system side is a valid/packet/wait handshake. On the link side there is a frame output, an 8-bit data output, and two asynchronous wait inputs: one pushes back read requests and the other pushes back writes.

A packet starts with a zero byte in the cycle where frame rises. Five header bytes follow, then four payload bytes. A 64-bit write adds four more payload bytes. A run of 64-bit writes to consecutive 8-byte addresses with the same control mode is sent as a burst. Frame stays high and each following packet sends only its payload bytes. Each wait input passes through a synchronizer. A synchronized wait only stops new packets from starting. A packet already on the wire always runs to its end.

Top module: `pkt_byte_serializer`

## Requirements
- R1: Out of reset, frame is low, data is 0x00 and sys_wait is low.
- R2: The byte sent in the cycle where frame rises is 0x00.
- R3: Header bytes 1 to 5 are {ctrl[7:4], dst[31:28]}, dst[27:20], dst[19:12], dst[11:4], and {dst[3:0], mode[3:2], write bit 1, valid bit 0}. Here ctrl, mode, dst, low word and high word are packet bits [7:4], [3:2], [39:8], [71:40] and [103:72].
- R4: A write whose mode is not 2'b11 sends the low word in bytes 6 to 9, most significant byte first. Frame drops after byte 9.
- R5: A read request (write bit 0, any mode) sends the high word, which holds the return address, in bytes 6 to 9. Frame drops after byte 9.
- R6: A 64-bit write (write bit 1, mode 2'b11) sends the low word in bytes 6 to 9 and then the high word in bytes 10 to 13, each word most significant byte first.
- R7: After byte 13, frame stays high only when the next packet is a 64-bit write whose dst equals the previous dst plus 8 and whose ctrl matches. That packet then begins directly at byte 6.
- R8: When the next packet does not qualify for a burst, frame goes low for at least one cycle and the next packet sends its full header.
- R9: A held-high write wait input keeps a write from starting, and a held-high read wait input keeps a read from starting. The wait of the other kind has no effect. Each wait passes through two register stages.
- R10: A packet that has started is sent in full even if a wait input rises while it is on the wire.
- R11: sys_wait is high while a packet is held waiting to start. A packet is accepted in a cycle where sys_access is high and sys_wait is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link byte clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_access | input | 1 | Packet valid on the system side |
| sys_packet | input | 104 | Transaction packet |
| sys_wait | output | 1 | Push-back to the system side |
| lnk_frame | output | 1 | Link frame |
| lnk_data | output | 8 | Link byte |
| lnk_rd_wait | input | 1 | Asynchronous read push-back from the far end |
| lnk_wr_wait | input | 1 | Asynchronous write push-back from the far end |

## Verification
The bench aims at the burst decision at byte 13:
- A design that ignores the address step or the ctrl match would glue unrelated writes into one frame and drop their headers.
- A design that never bursts would send a full header where only payload is expected.

Read requests check payload selection: a design that sends the data word instead of the return address shows up in bytes 6 to 9.

The wait tests raise one wait while a packet of the other kind goes out, and raise a wait mid-packet:
- A design that gates on the wrong wait would stall the packet that should go out.
- A design that aborts in flight would drop frame early and leave a short packet.

// File: rtl/pkt_ser_pkg.sv
package pkt_ser_pkg;

    localparam int PKT_W       = 104;
    localparam int BYTE_W      = 8;
    localparam int IDX_W       = 4;
    localparam int FIRST_PAY   = 6;
    localparam int LAST_SINGLE = 9;
    localparam int LAST_DOUBLE = 13;
    localparam int ADDR_STEP   = 8;
    localparam logic [1:0] MODE_DOUBLE = 2'b11;

    typedef struct packed {
        logic [31:0] hi_word;
        logic [31:0] lo_word;
        logic [31:0] dst;
        logic [3:0]  ctrl;
        logic [1:0]  mode;
        logic        write;
        logic        valid;
    } pkt_t;

    function automatic logic is_double(pkt_t p);
        return p.write && (p.mode == MODE_DOUBLE);
    endfunction

    function automatic logic [IDX_W-1:0] last_idx(pkt_t p);
        return is_double(p) ? IDX_W'(LAST_DOUBLE) : IDX_W'(LAST_SINGLE);
    endfunction

    function automatic logic burst_ok(pkt_t prev, pkt_t nxt);
        return is_double(prev) && is_double(nxt) && (nxt.ctrl == prev.ctrl)
            && (nxt.dst == prev.dst + 32'(ADDR_STEP));
    endfunction

    function automatic logic [BYTE_W-1:0] byte_at(pkt_t p, logic [IDX_W-1:0] idx);
        logic [31:0] first_word;
        logic [BYTE_W-1:0] b;
        first_word = p.write ? p.lo_word : p.hi_word;
        case (idx)
            4'd1:    b = {p.ctrl, p.dst[31:28]};
            4'd2:    b = p.dst[27:20];
            4'd3:    b = p.dst[19:12];
            4'd4:    b = p.dst[11:4];
            4'd5:    b = {p.dst[3:0], p.mode, p.write, p.valid};
            4'd6:    b = first_word[31:24];
            4'd7:    b = first_word[23:16];
            4'd8:    b = first_word[15:8];
            4'd9:    b = first_word[7:0];
            4'd10:   b = p.hi_word[31:24];
            4'd11:   b = p.hi_word[23:16];
            4'd12:   b = p.hi_word[15:8];
            4'd13:   b = p.hi_word[7:0];
            default: b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/pkt_wait_sync.sv
module pkt_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-2:0], async_in};
    end

    assign sync_out = shreg[STAGES-1];
endmodule

// File: rtl/pkt_hold_slot.sv
module pkt_hold_slot
    import pkt_ser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_req,
    input  pkt_t load_pkt,
    input  logic take,
    output logic full,
    output pkt_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else if (load_req && !full) begin
            full <= 1'b1;
            held <= load_pkt;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/pkt_tx_seq.sv
module pkt_tx_seq
    import pkt_ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pend_full,
    input  pkt_t               pend_pkt,
    input  logic               rd_blk,
    input  logic               wr_blk,
    output logic               take,
    output logic               frame,
    output logic [BYTE_W-1:0]  data,
    output logic [IDX_W-1:0]   idx,
    output logic               cur_write
);
    pkt_t cur;
    logic sending;
    logic at_last, start, cont, pend_blocked;

    assign pend_blocked = pend_pkt.write ? wr_blk : rd_blk;
    assign at_last      = sending && (idx == last_idx(cur));
    assign start        = !sending && pend_full && !pend_blocked;
    assign cont         = at_last && pend_full && !wr_blk && burst_ok(cur, pend_pkt);
    assign take         = start || cont;

    always_ff @(posedge clk) begin
        if (rst) begin
            sending <= 1'b0;
            idx     <= '0;
            cur     <= '0;
        end else if (start) begin
            cur     <= pend_pkt;
            sending <= 1'b1;
            idx     <= '0;
        end else if (cont) begin
            cur     <= pend_pkt;
            idx     <= IDX_W'(FIRST_PAY);
        end else if (at_last) begin
            sending <= 1'b0;
            idx     <= '0;
        end else if (sending) begin
            idx     <= idx + 1'b1;
        end
    end

    assign frame     = sending;
    assign data      = sending ? byte_at(cur, idx) : '0;
    assign cur_write = cur.write;
endmodule

// File: rtl/pkt_byte_serializer.sv
module pkt_byte_serializer
    import pkt_ser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_access,
    input  logic [PKT_W-1:0]  sys_packet,
    output logic              sys_wait,
    output logic              lnk_frame,
    output logic [BYTE_W-1:0] lnk_data,
    input  logic              lnk_rd_wait,
    input  logic              lnk_wr_wait
);
    localparam int N_WAIT = 2;

    logic [N_WAIT-1:0] wait_async, wait_s;
    logic pend_full, take, seq_cur_write;
    logic [IDX_W-1:0] seq_idx;
    pkt_t pend_pkt;

    assign wait_async = {lnk_wr_wait, lnk_rd_wait};

    for (genvar i = 0; i < N_WAIT; i++) begin : g_sync
        pkt_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst(rst), .async_in(wait_async[i]), .sync_out(wait_s[i])
        );
    end

    pkt_hold_slot u_slot (
        .clk(clk), .rst(rst), .load_req(sys_access), .load_pkt(pkt_t'(sys_packet)),
        .take(take), .full(pend_full), .held(pend_pkt)
    );

    pkt_tx_seq u_seq (
        .clk(clk), .rst(rst), .pend_full(pend_full), .pend_pkt(pend_pkt),
        .rd_blk(wait_s[0]), .wr_blk(wait_s[1]), .take(take),
        .frame(lnk_frame), .data(lnk_data), .idx(seq_idx), .cur_write(seq_cur_write)
    );

    assign sys_wait = pend_full;
endmodule

// File: rtl/pkt_byte_serializer_chk.sv
module pkt_byte_serializer_chk (
    input logic       clk,
    input logic       rst,
    input logic       sys_access,
    input logic       sys_wait,
    input logic       frame,
    input logic [7:0] data,
    input logic [3:0] idx,
    input logic       cur_write,
    input logic       rd_blk,
    input logic       wr_blk
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!frame && !sys_wait && data == 8'h00)); // R1
    AST_START_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(frame) |-> data == 8'h00); // R2
    AST_HEADER_STEP: assert property (@(posedge clk) disable iff (rst)
        (frame && $past(frame) && $past(idx) < 4'd5) |-> idx == $past(idx) + 4'd1); // R3
    AST_BURST_RESUME: assert property (@(posedge clk) disable iff (rst)
        (frame && $past(frame) && $past(idx) == 4'd13) |-> idx == 4'd6); // R7
    AST_WR_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($rose(frame) && cur_write) |-> !$past(wr_blk)); // R9
    AST_RD_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($rose(frame) && !cur_write) |-> !$past(rd_blk)); // R9
    AST_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
        (frame && idx != 4'd9 && idx != 4'd13) |=> frame); // R10
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (sys_access && !sys_wait) |=> sys_wait); // R11
endmodule

bind pkt_byte_serializer pkt_byte_serializer_chk u_chk (
    .clk(clk), .rst(rst), .sys_access(sys_access), .sys_wait(sys_wait),
    .frame(lnk_frame), .data(lnk_data), .idx(seq_idx), .cur_write(seq_cur_write),
    .rd_blk(wait_s[0]), .wr_blk(wait_s[1])
);

// File: tb/pkt_byte_serializer_bench.sv
module pkt_byte_serializer_bench;
    logic clk = 1'b0, rst = 1'b1, sys_access = 1'b0, rd_w = 1'b0, wr_w = 1'b0;
    logic [103:0] sys_packet = '0;
    logic sys_wait, frame;
    logic [7:0] data;
    int checks = 0, fails = 0, starts = 0, bursts = 0, done_pk = 0, cyc = 0;
    logic [103:0] exp_q[$];
    logic [103:0] cur, last_sent;
    bit inpk = 0, finished = 0;
    int idx = 0;

    always #4 clk = ~clk;

    pkt_byte_serializer u_pkt_byte_serializer (
        .clk(clk), .rst(rst), .sys_access(sys_access), .sys_packet(sys_packet),
        .sys_wait(sys_wait), .lnk_frame(frame), .lnk_data(data),
        .lnk_rd_wait(rd_w), .lnk_wr_wait(wr_w)
    );

    function automatic int elast(logic [103:0] p);
        return (p[1] && p[3:2] == 2'b11) ? 13 : 9;
    endfunction

    function automatic bit elig(logic [103:0] a, logic [103:0] b);
        return elast(a) == 13 && elast(b) == 13 && a[7:4] == b[7:4]
            && b[39:8] == a[39:8] + 32'd8;
    endfunction

    function automatic logic [7:0] eb(logic [103:0] p, int i);
        logic [31:0] d, pay, hi;
        d = p[39:8]; hi = p[103:72]; pay = p[1] ? p[71:40] : hi;
        case (i)
            0: return 8'h00;
            1: return {p[7:4], d[31:28]};
            2: return d[27:20];
            3: return d[19:12];
            4: return d[11:4];
            5: return {d[3:0], p[3:2], p[1], p[0]};
            6, 7, 8, 9: return pay[8*(9-i) +: 8];
            default: return hi[8*(13-i) +: 8];
        endcase
    endfunction

    function automatic string rtag(logic [103:0] p, int i);
        if (i <= 5) return "R3";
        if (i >= 10 || elast(p) == 13) return "R6";
        return p[1] ? "R4" : "R5";
    endfunction

    task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // Link monitor: rebuilds the expected stream from the accepted packets
    always @(negedge clk) begin
        if (!rst) begin
            if (frame && !inpk) begin
                chk(data == 8'h00, "R2", data, 0);
                starts++;
                if (exp_q.size() == 0) chk(0, "R11 unexpected packet", 0, 1);
                else cur = exp_q.pop_front();
                idx = 1; inpk = 1;
            end else if (frame && inpk) begin
                if (idx == elast(cur) + 1) begin
                    chk(exp_q.size() > 0 && elig(cur, exp_q[0]), "R7 burst on ineligible", 0, 1);
                    if (exp_q.size() > 0) cur = exp_q.pop_front();
                    idx = 6; bursts++;
                end
                chk(data == eb(cur, idx), rtag(cur, idx), data, eb(cur, idx));
                idx++;
            end else if (!frame && inpk) begin
                chk(idx == elast(cur) + 1, idx == 14 ? "R10 length" : (elast(cur) == 13 ? "R6 length" : "R4/R5 length"), idx, elast(cur) + 1);
                inpk = 0; done_pk++; last_sent = cur;
            end
        end
    end

    task automatic send(logic [103:0] p);
        bit w;
        @(negedge clk);
        sys_access = 1'b1; sys_packet = p;
        forever begin
            w = sys_wait;
            @(negedge clk);
            if (!w) break;
        end
        exp_q.push_back(p);
        sys_access = 1'b0;
    endtask

    function automatic logic [103:0] mk(bit wr, logic [1:0] md, logic [3:0] c, logic [31:0] dst);
        return {$urandom(), $urandom(), dst, c, md, wr, 1'b1};
    endfunction

    task automatic drain();
        repeat (40) @(negedge clk);
    endtask

    initial begin
        int s0, b0;
        logic [103:0] p, q;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!frame && data == 0 && !sys_wait, "R1", {frame, data, sys_wait}, 0);

        // directed: each packet kind
        send(mk(1, 2'b10, 4'h3, 32'h1234_5678)); drain();   // R4
        send(mk(0, 2'b11, 4'h1, 32'hA000_0010)); drain();   // R5
        send(mk(1, 2'b11, 4'h0, 32'h0000_0100)); drain();   // R6

        // R7: sequential 64-bit writes chain into one frame
        b0 = bursts; s0 = starts;
        p = mk(1, 2'b11, 4'h5, 32'h8000_0040);
        q = mk(1, 2'b11, 4'h5, 32'h8000_0048);
        send(p); send(q); drain();
        chk(bursts == b0 + 1 && starts == s0 + 1, "R7", bursts - b0, 1);

        // R8: address gap and ctrl mismatch force a new header
        b0 = bursts; s0 = starts;
        send(mk(1, 2'b11, 4'h5, 32'h8000_0100));
        send(mk(1, 2'b11, 4'h5, 32'h8000_0110));
        send(mk(1, 2'b11, 4'h6, 32'h8000_0118));
        drain();
        chk(bursts == b0 && starts == s0 + 3, "R8", starts - s0, 3);

        // R9: write wait held has no effect on a read
        wr_w = 1'b1; repeat (4) @(negedge clk);
        s0 = done_pk;
        send(mk(0, 2'b10, 4'h0, 32'h4000_0000)); drain();
        chk(done_pk == s0 + 1, "R9 read passes write wait", done_pk - s0, 1);
        // R9: write held back while write wait high
        s0 = starts;
        send(mk(1, 2'b10, 4'h2, 32'h4000_0020));
        repeat (30) @(negedge clk);
        chk(starts == s0, "R9 write blocked", starts - s0, 0);
        chk(sys_wait == 1'b1, "R11 held packet raises wait", sys_wait, 1);
        wr_w = 1'b0; drain();
        chk(starts == s0 + 1, "R9 write resumes", starts - s0, 1);
        chk(sys_wait == 1'b0, "R11 wait clears", sys_wait, 0);
        // R9: read held back by read wait
        rd_w = 1'b1; repeat (4) @(negedge clk);
        s0 = starts;
        send(mk(0, 2'b00, 4'h0, 32'h4000_0040));
        repeat (20) @(negedge clk);
        chk(starts == s0, "R9 read blocked", starts - s0, 0);
        rd_w = 1'b0; drain();
        chk(starts == s0 + 1, "R9 read resumes", starts - s0, 1);

        // R10: wait rises mid-packet, packet completes
        s0 = done_pk;
        fork
            send(mk(1, 2'b11, 4'h0, 32'h2000_0000));
            begin
                while (!frame) @(negedge clk);
                repeat (2) @(negedge clk);
                wr_w = 1'b1;
            end
        join
        repeat (30) @(negedge clk);
        wr_w = 1'b0; drain();
        chk(done_pk == s0 + 1, "R10", done_pk - s0, 1);

        // random mix, some sequential bursts
        p = mk(1, 2'b11, 4'h0, 32'h0000_1000);
        for (int n = 0; n < 60; n++) begin
            if (($urandom() % 3) == 0 && elast(p) == 13)
                q = mk(1, 2'b11, p[7:4], p[39:8] + 32'd8);
            else
                q = mk(1'($urandom()), 2'($urandom()), 4'($urandom()), $urandom());
            send(q); p = q;
        end
        drain();
        chk(exp_q.size() == 0 && !inpk, "R11 all accepted packets sent", exp_q.size(), 0);
        finished = 1;
    end

    initial begin
        while (!finished && cyc < 100000) begin
            @(posedge clk); cyc++;
        end
        if (!finished) chk(0, "watchdog", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule